// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block holds wall-clock time and date as seven packed-BCD registers: seconds, minutes, hours (24-hour), weekday, day of month, month and a two-digit year. A prescaler supplies a strobe once per second. Each strobe advances the time by one second. The carry ripples through minutes, hours, days, months and years. Day rollover follows the length of the current month, and February gains a 29th day in leap years.

A host writes any single field by giving a field code and a data byte. It reads any field through a combinational read port that is selected by the same field codes. While software is setting the clock, a freeze input holds the whole calendar still. The year register stores only two digits; software reads 50–99 as 1950–1999 and 00–49 as 2000–2049. The leap test looks at the two stored digits only.

Top module: `bcd_calendar`

## Requirements
- R1: Every field is packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. `rd_data_o` shows the field picked by `rd_sel_i` in the same cycle, using these codes: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year. Code 7 reads 0x00.
- R2: After reset the fields read 00 seconds, 00 minutes, 00 hours, weekday 07, day 01, month 01 and year 00.
- R3: A tick strobe that is not blocked adds one second with a decimal digit carry, so 09 becomes 10 and 56 becomes 57.
- R4: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours.
- R5: Hours count 00 to 23. The step from 23 to 00 advances both the day of month and the weekday.
- R6: The weekday counts 1 to 7, with 1 meaning Sunday, and wraps from 07 to 01.
- R7: The day of month wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other non-February months. That wrap advances the month, and month 12 wraps to 01 and advances the year.
- R8: February wraps after day 29 when the two-digit year is divisible by 4, including 00, and after day 28 otherwise.
- R9: The year counts 00 to 99 and wraps from 99 to 00.
- R10: While `freeze_i` is 1, tick strobes are ignored and no field changes.
- R11: A write loads `wr_data_i` into the field coded by `wr_sel_i` at the next clock edge. A tick in the same cycle is dropped, so no other field advances in that cycle.
- R12: If the stored day of month is already past the length of its month, the next day carry sets it to 01 and advances the month.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| freeze_i | input | 1 | Holds the time while high |
| wr_en_i | input | 1 | Field write enable |
| wr_sel_i | input | 3 | Field code for a write |
| wr_data_i | input | 8 | BCD value to write |
| rd_sel_i | input | 3 | Field code for a read |
| rd_data_o | output | 8 | Selected field, packed BCD |

## Verification
Each vector preloads a full date and time and then applies one tick, so each vector isolates one carry depth. A plain units step and a tens-digit step show that the counters use decimal digits and not binary. Rollovers at 59 seconds, at 59 minutes and at 23:59:59 show how far the carry ripples. End-of-month cases in 30-day months, 31-day months and February, across leap, non-leap, year 00 and odd-tens years, separate the month-length and leap decode from a fixed-length day counter. Directed cases apply ticks while frozen and a write in the same cycle as a tick; only a correct block blocks the advance in both.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int FIELD_W = 8;
  localparam int DIGITS  = FIELD_W / 4;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_MDAY = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6,
    FLD_NONE = 3'd7
  } field_e;

  // Decimal increment of a packed-BCD value, one digit at a time
  function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
    logic [FIELD_W-1:0] r;
    logic               c;
    r = v;
    c = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (c) begin
        if (r[d*4 +: 4] >= 4'd9) begin
          r[d*4 +: 4] = 4'd0;
        end else begin
          r[d*4 +: 4] = r[d*4 +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/bcd_wrap_ctr.sv
module bcd_wrap_ctr
  import bcd_cal_pkg::*;
#(
  parameter logic [FIELD_W-1:0] LO  = 8'h00,
  parameter logic [FIELD_W-1:0] RST = LO
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_i,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] load_val_i,
  input  logic [FIELD_W-1:0] max_i,
  output logic [FIELD_W-1:0] val_o
);
  logic [FIELD_W-1:0] val_q;
  logic [FIELD_W-1:0] val_d;
  logic               val_en;

  always_comb begin
    val_en = load_i | inc_i;
    if (load_i) begin
      val_d = load_val_i;
    end else if (val_q >= max_i) begin
      val_d = LO;
    end else begin
      val_d = bcd_inc(val_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= RST;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/bcd_month_len.sv
module bcd_month_len
  import bcd_cal_pkg::*;
(
  input  logic [FIELD_W-1:0] mon_i,
  input  logic [FIELD_W-1:0] yr_i,
  output logic [FIELD_W-1:0] days_o
);
  logic leap;

  always_comb begin
    // Divisible by 4: even tens with units 0/4/8, odd tens with units 2/6
    if (!yr_i[4]) begin
      leap = (yr_i[3:0] == 4'd0) || (yr_i[3:0] == 4'd4) || (yr_i[3:0] == 4'd8);
    end else begin
      leap = (yr_i[3:0] == 4'd2) || (yr_i[3:0] == 4'd6);
    end

    unique case (mon_i)
      8'h02:                      days_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: days_o = 8'h30;
      default:                    days_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter logic [FIELD_W-1:0] RST_WDAY = 8'h07,
  parameter logic [FIELD_W-1:0] RST_MDAY = 8'h01,
  parameter logic [FIELD_W-1:0] RST_MON  = 8'h01,
  parameter logic [FIELD_W-1:0] RST_YEAR = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               freeze_i,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [FIELD_W-1:0] rd_data_o
);
  logic [FIELD_W-1:0] sec_q, min_q, hr_q, wday_q, mday_q, mon_q, yr_q;
  logic [FIELD_W-1:0] mday_max;
  logic               adv;
  logic               c_sec, c_min, c_hr, c_mday, c_mon;

  // A write in the same cycle drops the tick
  assign adv    = tick_i & ~freeze_i & ~wr_en_i;
  assign c_sec  = adv   & (sec_q  >= 8'h59);
  assign c_min  = c_sec & (min_q  >= 8'h59);
  assign c_hr   = c_min & (hr_q   >= 8'h23);
  assign c_mday = c_hr  & (mday_q >= mday_max);
  assign c_mon  = c_mday & (mon_q >= 8'h12);

  bcd_month_len u_len (
    .mon_i  (mon_q),
    .yr_i   (yr_q),
    .days_o (mday_max)
  );

  bcd_wrap_ctr #(.LO(8'h00), .RST(8'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc_i(adv),
    .load_i(wr_en_i && (wr_sel_i == FLD_SEC)), .load_val_i(wr_data_i),
    .max_i(8'h59), .val_o(sec_q));

  bcd_wrap_ctr #(.LO(8'h00), .RST(8'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .inc_i(c_sec),
    .load_i(wr_en_i && (wr_sel_i == FLD_MIN)), .load_val_i(wr_data_i),
    .max_i(8'h59), .val_o(min_q));

  bcd_wrap_ctr #(.LO(8'h00), .RST(8'h00)) u_hr (
    .clk(clk), .rst_n(rst_n), .inc_i(c_min),
    .load_i(wr_en_i && (wr_sel_i == FLD_HOUR)), .load_val_i(wr_data_i),
    .max_i(8'h23), .val_o(hr_q));

  bcd_wrap_ctr #(.LO(8'h01), .RST(RST_WDAY)) u_wday (
    .clk(clk), .rst_n(rst_n), .inc_i(c_hr),
    .load_i(wr_en_i && (wr_sel_i == FLD_WDAY)), .load_val_i(wr_data_i),
    .max_i(8'h07), .val_o(wday_q));

  bcd_wrap_ctr #(.LO(8'h01), .RST(RST_MDAY)) u_mday (
    .clk(clk), .rst_n(rst_n), .inc_i(c_hr),
    .load_i(wr_en_i && (wr_sel_i == FLD_MDAY)), .load_val_i(wr_data_i),
    .max_i(mday_max), .val_o(mday_q));

  bcd_wrap_ctr #(.LO(8'h01), .RST(RST_MON)) u_mon (
    .clk(clk), .rst_n(rst_n), .inc_i(c_mday),
    .load_i(wr_en_i && (wr_sel_i == FLD_MON)), .load_val_i(wr_data_i),
    .max_i(8'h12), .val_o(mon_q));

  bcd_wrap_ctr #(.LO(8'h00), .RST(RST_YEAR)) u_yr (
    .clk(clk), .rst_n(rst_n), .inc_i(c_mon),
    .load_i(wr_en_i && (wr_sel_i == FLD_YEAR)), .load_val_i(wr_data_i),
    .max_i(8'h99), .val_o(yr_q));

  always_comb begin
    unique case (rd_sel_i)
      FLD_SEC:  rd_data_o = sec_q;
      FLD_MIN:  rd_data_o = min_q;
      FLD_HOUR: rd_data_o = hr_q;
      FLD_WDAY: rd_data_o = wday_q;
      FLD_MDAY: rd_data_o = mday_q;
      FLD_MON:  rd_data_o = mon_q;
      FLD_YEAR: rd_data_o = yr_q;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
  import bcd_cal_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               tick_i,
  input logic               freeze_i,
  input logic               wr_en_i,
  input logic [SEL_W-1:0]   wr_sel_i,
  input logic [FIELD_W-1:0] wr_data_i,
  input logic [SEL_W-1:0]   rd_sel_i,
  input logic [FIELD_W-1:0] rd_data_o,
  input logic [FIELD_W-1:0] sec_q,
  input logic [FIELD_W-1:0] min_q,
  input logic [FIELD_W-1:0] hr_q,
  input logic [FIELD_W-1:0] wday_q,
  input logic [FIELD_W-1:0] mday_q,
  input logic [FIELD_W-1:0] mon_q,
  input logic [FIELD_W-1:0] yr_q
);
  logic go;
  logic eod;
  assign go  = tick_i && !freeze_i && !wr_en_i;
  assign eod = (hr_q == 8'h23) && (min_q == 8'h59) && (sec_q == 8'h59);

  assert_unused_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_i == 3'd7) |-> (rd_data_o == 8'h00));

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && sec_q == 8'h59) |=> (sec_q == 8'h00));

  assert_midnight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && eod) |=> (hr_q == 8'h00 && mday_q != $past(mday_q)));

  assert_wday_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && eod && wday_q == 8'h07) |=> (wday_q == 8'h01));

  assert_year_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && eod && mday_q == 8'h31 && mon_q == 8'h12 && yr_q == 8'h99)
      |=> (yr_q == 8'h00 && mon_q == 8'h01));

  assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q)
      && $stable(wday_q) && $stable(mday_q) && $stable(mon_q) && $stable(yr_q)));

  assert_write_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 3'd1) |=> (min_q == $past(wr_data_i)));

  assert_write_blocks_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i != 3'd0) |=> $stable(sec_q));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freeze_i(freeze_i),
  .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
  .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
  .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q), .wday_q(wday_q),
  .mday_q(mday_q), .mon_q(mon_q), .yr_q(yr_q)
);

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/1ps
module sim_bcd_calendar;
  logic       clk;
  logic       rst_n;
  logic       tick_i, freeze_i, wr_en_i;
  logic [2:0] wr_sel_i, rd_sel_i;
  logic [7:0] wr_data_i, rd_data_o;

  int n_chk;
  int n_bad;
  bit done;

  bcd_calendar u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freeze_i(freeze_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Vector: {req number, start time, expected after one tick}
  // Time packing, high to low: year, month, mday, wday, hour, min, sec
  localparam int NV = 18;
  localparam logic [119:0] VEC [NV] = '{
    {8'd3,  56'h00_01_01_07_00_00_09, 56'h00_01_01_07_00_00_10}, // R3
    {8'd3,  56'h00_01_01_07_12_34_56, 56'h00_01_01_07_12_34_57}, // R3
    {8'd4,  56'h00_01_01_07_00_00_59, 56'h00_01_01_07_00_01_00}, // R4
    {8'd4,  56'h00_01_01_07_05_59_59, 56'h00_01_01_07_06_00_00}, // R4
    {8'd5,  56'h00_01_01_03_23_59_59, 56'h00_01_02_04_00_00_00}, // R5
    {8'd6,  56'h00_01_10_07_23_59_59, 56'h00_01_11_01_00_00_00}, // R6
    {8'd7,  56'h23_04_30_02_23_59_59, 56'h23_05_01_03_00_00_00}, // R7
    {8'd7,  56'h23_01_31_02_23_59_59, 56'h23_02_01_03_00_00_00}, // R7
    {8'd7,  56'h23_09_30_01_23_59_59, 56'h23_10_01_02_00_00_00}, // R7
    {8'd7,  56'h23_11_30_01_23_59_59, 56'h23_12_01_02_00_00_00}, // R7
    {8'd9,  56'h99_12_31_05_23_59_59, 56'h00_01_01_06_00_00_00}, // R9
    {8'd8,  56'h24_02_28_01_23_59_59, 56'h24_02_29_02_00_00_00}, // R8
    {8'd8,  56'h23_02_28_01_23_59_59, 56'h23_03_01_02_00_00_00}, // R8
    {8'd8,  56'h00_02_28_01_23_59_59, 56'h00_02_29_02_00_00_00}, // R8
    {8'd8,  56'h24_02_29_01_23_59_59, 56'h24_03_01_02_00_00_00}, // R8
    {8'd8,  56'h96_02_28_01_23_59_59, 56'h96_02_29_02_00_00_00}, // R8
    {8'd8,  56'h98_02_28_01_23_59_59, 56'h98_03_01_02_00_00_00}, // R8
    {8'd12, 56'h23_02_31_01_23_59_59, 56'h23_03_01_02_00_00_00}  // R12
  };

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic check(input int req, input logic [55:0] act, input logic [55:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_field(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = val;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic load_all(input logic [55:0] t);
    write_field(3'd0, t[7:0]);
    write_field(3'd1, t[15:8]);
    write_field(3'd2, t[23:16]);
    write_field(3'd3, t[31:24]);
    write_field(3'd4, t[39:32]);
    write_field(3'd5, t[47:40]);
    write_field(3'd6, t[55:48]);
  endtask

  task automatic one_tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic read_all(output logic [55:0] t);
    for (int f = 0; f < 7; f++) begin
      rd_sel_i = f[2:0];
      #0.5;
      t[f*8 +: 8] = rd_data_o;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [55:0] got;
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; tick_i = 0; freeze_i = 0; wr_en_i = 0;
    wr_sel_i = 0; wr_data_i = 0; rd_sel_i = 0;
    repeat (3) @(negedge clk);
    read_all(got);
    check(2, got, 56'h00_01_01_07_00_00_00); // R2 during reset
    rst_n = 1'b1;
    @(negedge clk);
    read_all(got);
    check(2, got, 56'h00_01_01_07_00_00_00); // R2 after release

    rd_sel_i = 3'd7; #0.5;
    check(1, {48'd0, rd_data_o}, 56'd0);     // R1 unused code reads zero

    // Table walk: R3 R4 R5 R6 R7 R8 R9 R12
    for (int v = 0; v < NV; v++) begin
      load_all(VEC[v][111:56]);
      read_all(got);
      check(1, got, VEC[v][111:56]);          // R1 readback of loaded fields
      one_tick();
      read_all(got);
      check(int'(VEC[v][119:112]), got, VEC[v][55:0]);
    end

    // R10: freeze blocks ticks, release resumes
    load_all(56'h23_06_15_02_10_20_30);
    @(negedge clk); freeze_i = 1'b1;
    repeat (4) one_tick();
    read_all(got);
    check(10, got, 56'h23_06_15_02_10_20_30);
    @(negedge clk); freeze_i = 1'b0;
    one_tick();
    read_all(got);
    check(10, got, 56'h23_06_15_02_10_20_31);

    // R11: write with simultaneous tick at 23:59:59, nothing else advances
    load_all(56'h23_06_15_02_23_59_59);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd1; wr_data_i = 8'h42;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    read_all(got);
    check(11, got, 56'h23_06_15_02_23_42_59);

    // R11: write to the seconds field wins over a same-cycle tick
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 8'h05;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    read_all(got);
    check(11, got, 56'h23_06_15_02_23_42_05);

    done = 1;
    report();
  end
endmodule